// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block sits on the master side of an asynchronous bus and decides how each bus cycle ends. When a request arrives, it drives the address strobe and holds the cycle open, adding wait states, until a responder answers. Three active-low response lines are involved: data acknowledge, bus error and halt. The controller samples them on rising clock edges at a reference state N and, in one variant, again two states later at N+2. From these samples it reports exactly one of four outcomes through one-clock strobes: normal completion, normal completion followed by a halt, a bus-error trap, or a retry that waits for halt to be released.

The parameter `LATE_ERR` selects the variant. With `LATE_ERR = 0` the outcome is fixed at N. With `LATE_ERR = 1`, an acknowledged cycle is held until N+2, so a bus error that arrives after the acknowledge can still turn the cycle into a trap or a retry. A retried cycle is reissued with the latched address and direction, and a new request cannot take its place.

Top module: `bus_term_ctrl`

## Requirements
- R1: While reset is held and directly after it, `as_no` is 1, all four outcome strobes are 0 and `halted_o` is 0.
- R2: A cycle starts only from idle, with `req_i` at 1 and both `dtack_ni` and `berr_ni` at 1 on the same edge. `as_no` is 0 from the next cycle, with `addr_o`/`we_o` holding the request values. While either line is 0, `as_no` stays 1.
- R3: Counting the edge that starts the cycle as edge 0, response lines are sampled only at odd edges k >= FIRST_N+1 (edge 5 by default). The reference point N is the first of these edges at which acknowledge or bus error is 0. An outcome decided at an edge shows on its strobe for the cycle that follows it.
- R4: Acknowledge at N with bus error and halt both 1 gives `ok_o` in both variants. In the late variant this also needs bus error to stay 1 at N+2.
- R5: Acknowledge with halt 0 at N, and no bus error, gives `ok_halt_o`. `halted_o` then stays 1 while `halt_ni` is 0, `as_no` stays 1, and the controller returns to idle once halt is 1.
- R6: Bus error at N with halt at 1 gives `trap_o`, whatever acknowledge does.
- R7: Bus error and halt together at N give `retry_o`, whatever acknowledge does, and `halted_o` rises with the strobe.
- R8: With `LATE_ERR = 0`, a bus error (with or without halt) that first appears after N has no effect: the outcome fixed at N stands and no further strobe follows.
- R9: With `LATE_ERR = 1`, acknowledge at N without bus error defers the decision to N+2. At N+2, bus error alone gives `trap_o`, and bus error with halt gives `retry_o`. If bus error is absent at N+2, halt at N or N+2 gives `ok_halt_o`, and otherwise the result is `ok_o`.
- R10: Each cycle yields exactly one strobe, at most one strobe is 1 at a time, and every strobe is one clock wide.
- R11: After `retry_o`, requests are ignored. On the edge where `halt_ni` is 1 and acknowledge and bus error are both 1, the cycle is reissued: `as_no` goes to 0 the next cycle, with the same `addr_o` and `we_o` as the failed cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request for a new bus cycle |
| addr_i | input | AW | Address of the requested cycle |
| we_i | input | 1 | Direction of the requested cycle, 1 = write |
| dtack_ni | input | 1 | Data acknowledge from the responder, active low |
| berr_ni | input | 1 | Bus error from the responder, active low |
| halt_ni | input | 1 | Halt request, active low |
| as_no | output | 1 | Address strobe, active low, 0 while the cycle is open |
| addr_o | output | AW | Address of the current or retried cycle |
| we_o | output | 1 | Direction of the current or retried cycle |
| ok_o | output | 1 | Strobe: normal completion, continue |
| ok_halt_o | output | 1 | Strobe: normal completion, then halt |
| trap_o | output | 1 | Strobe: bus error trap |
| retry_o | output | 1 | Strobe: cycle terminated, retry after halt |
| halted_o | output | 1 | Controller stalled waiting for halt release |

## Verification
The hardest situation to create is a bus error that arrives after the reference point in the late-error variant. It must be seen at N+2 and not at N, and this window exists only after the acknowledge has already been accepted. The stimulus waits until the address strobe rises, which in that variant marks the edge at N, and then drives bus error, with or without halt. The same late drive, applied to the basic variant just after its strobe, shows that the outcome already given stays unchanged. Random wait states before the response cover every sampling parity.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_LATE,
    ST_HOLD
  } bct_state_e;

  typedef enum logic [2:0] {
    OC_NONE,
    OC_WAIT,
    OC_OK,
    OC_OK_HALT,
    OC_TRAP,
    OC_RETRY
  } bct_oc_e;

  // response lines, active high
  typedef struct packed {
    logic ack;
    logic err;
    logic hlt;
  } bct_rsp_t;

endpackage

// File: rtl/bct_timer.sv
module bct_timer #(
  parameter int unsigned FIRST_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic ref_o,
  output logic two_o
);
  localparam int unsigned CW = $clog2(FIRST_N + 2);
  localparam logic [CW-1:0] REF_V  = CW'(FIRST_N);
  localparam logic [CW-1:0] WRAP_V = CW'(FIRST_N + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q == WRAP_V) cnt_q <= REF_V;  // wait states: toggle around N
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign ref_o = (cnt_q == REF_V);
  assign two_o = (cnt_q == CW'(1));
endmodule

// File: rtl/bct_decide.sv
module bct_decide import bct_pkg::*; #(
  parameter bit LATE_ERR = 1'b1
) (
  input  logic     first_i,
  input  logic     second_i,
  input  bct_rsp_t rsp_i,
  input  logic     halt_n_i,
  output bct_oc_e  oc_o
);
  bct_oc_e ack_oc;

  generate
    if (LATE_ERR) begin : g_late
      assign ack_oc = OC_WAIT;
    end else begin : g_basic
      assign ack_oc = rsp_i.hlt ? OC_OK_HALT : OC_OK;
    end
  endgenerate

  always_comb begin
    oc_o = OC_NONE;
    if (first_i) begin
      if (rsp_i.err)      oc_o = rsp_i.hlt ? OC_RETRY : OC_TRAP;
      else if (rsp_i.ack) oc_o = ack_oc;
    end else if (second_i) begin
      if (rsp_i.err) oc_o = rsp_i.hlt ? OC_RETRY : OC_TRAP;
      else           oc_o = (rsp_i.hlt || halt_n_i) ? OC_OK_HALT : OC_OK;
    end
  end
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl import bct_pkg::*; #(
  parameter int unsigned AW       = 24,
  parameter int unsigned FIRST_N  = 4,
  parameter bit          LATE_ERR = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          dtack_ni,
  input  logic          berr_ni,
  input  logic          halt_ni,
  output logic          as_no,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic          ok_o,
  output logic          ok_halt_o,
  output logic          trap_o,
  output logic          retry_o,
  output logic          halted_o
);
  bct_state_e    state_q;
  bct_oc_e       oc;
  bct_rsp_t      rsp;
  logic          retry_q, halt_n_q, we_q;
  logic [AW-1:0] addr_q;
  logic [3:0]    strb_q;
  logic          at_ref, at_two, first, second, tmr_clr, lines_free;

  assign rsp        = '{ack: ~dtack_ni, err: ~berr_ni, hlt: ~halt_ni};
  assign lines_free = dtack_ni & berr_ni;
  assign first      = (state_q == ST_RUN)  && at_ref;
  assign second     = (state_q == ST_LATE) && at_two;
  assign tmr_clr    = !((state_q == ST_RUN) || (state_q == ST_LATE)) || (oc == OC_WAIT);

  bct_timer #(.FIRST_N(FIRST_N)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .ref_o (at_ref),
    .two_o (at_two)
  );

  bct_decide #(.LATE_ERR(LATE_ERR)) u_decide (
    .first_i (first),
    .second_i(second),
    .rsp_i   (rsp),
    .halt_n_i(halt_n_q),
    .oc_o    (oc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      retry_q  <= 1'b0;
      halt_n_q <= 1'b0;
      addr_q   <= '0;
      we_q     <= 1'b0;
      strb_q   <= '0;
    end else begin
      strb_q <= '0;
      case (state_q)
        ST_IDLE: begin
          if (req_i && lines_free) begin
            state_q <= ST_RUN;
            addr_q  <= addr_i;
            we_q    <= we_i;
          end
        end
        ST_RUN, ST_LATE: begin
          case (oc)
            OC_WAIT: begin
              state_q  <= ST_LATE;
              halt_n_q <= rsp.hlt;
            end
            OC_OK: begin
              state_q   <= ST_IDLE;
              strb_q[0] <= 1'b1;
            end
            OC_OK_HALT: begin
              state_q   <= ST_HOLD;
              strb_q[1] <= 1'b1;
            end
            OC_TRAP: begin
              state_q   <= ST_IDLE;
              strb_q[2] <= 1'b1;
            end
            OC_RETRY: begin
              state_q   <= ST_HOLD;
              retry_q   <= 1'b1;
              strb_q[3] <= 1'b1;
            end
            default: ;
          endcase
        end
        ST_HOLD: begin
          if (halt_ni) begin
            if (!retry_q) begin
              state_q <= ST_IDLE;
            end else if (lines_free) begin
              state_q <= ST_RUN;  // reissue latched address
              retry_q <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign as_no     = (state_q != ST_RUN);
  assign addr_o    = addr_q;
  assign we_o      = we_q;
  assign ok_o      = strb_q[0];
  assign ok_halt_o = strb_q[1];
  assign trap_o    = strb_q[2];
  assign retry_o   = strb_q[3];
  assign halted_o  = (state_q == ST_HOLD);
endmodule

// File: rtl/bct_chk.sv
module bct_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          as_no,
  input logic [AW-1:0] addr_o,
  input logic          dtack_ni,
  input logic          berr_ni,
  input logic          halt_ni,
  input logic          halted_o,
  input logic [3:0]    strb_i
);
  logic          pend_q;
  logic [AW-1:0] ret_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      ret_addr_q <= '0;
    end else if (strb_i[3]) begin
      pend_q     <= 1'b1;
      ret_addr_q <= addr_o;
    end else if (!as_no) begin
      pend_q <= 1'b0;
    end
  end

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb_i));

  a_r10_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strb_i) |=> !(|strb_i));

  a_r2_lines_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(as_no) |-> ($past(dtack_ni) && $past(berr_ni)));

  a_r5_hold_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !halt_ni) |=> (halted_o && as_no));

  a_r7_retry_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i[3] |-> halted_o);

  a_r11_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !as_no) |-> (addr_o == ret_addr_q));
endmodule

bind bus_term_ctrl bct_chk #(.AW(AW)) u_bct_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .as_no   (as_no),
  .addr_o  (addr_o),
  .dtack_ni(dtack_ni),
  .berr_ni (berr_ni),
  .halt_ni (halt_ni),
  .halted_o(halted_o),
  .strb_i  ({retry_o, trap_o, ok_halt_o, ok_o})
);

// File: tb/tb_bus_term_ctrl.sv
`timescale 1ns/1ps
module tb_bus_term_ctrl;
  localparam int unsigned AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // index 1: late-error variant (dut), index 0: basic variant
  logic          req  [2];
  logic [AW-1:0] ai   [2];
  logic          wi   [2];
  logic          dtn  [2];
  logic          ben  [2];
  logic          hn   [2];
  logic          asn  [2];
  logic [AW-1:0] ao   [2];
  logic          wo   [2];
  logic          ok   [2];
  logic          okh  [2];
  logic          trp  [2];
  logic          rty  [2];
  logic          hlt  [2];

  int n_chk = 0;
  int n_err = 0;

  bus_term_ctrl #(.AW(AW), .FIRST_N(4), .LATE_ERR(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[1]), .addr_i(ai[1]), .we_i(wi[1]),
    .dtack_ni(dtn[1]), .berr_ni(ben[1]), .halt_ni(hn[1]),
    .as_no(asn[1]), .addr_o(ao[1]), .we_o(wo[1]),
    .ok_o(ok[1]), .ok_halt_o(okh[1]), .trap_o(trp[1]), .retry_o(rty[1]), .halted_o(hlt[1]));

  bus_term_ctrl #(.AW(AW), .FIRST_N(4), .LATE_ERR(1'b0)) dut_basic (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[0]), .addr_i(ai[0]), .we_i(wi[0]),
    .dtack_ni(dtn[0]), .berr_ni(ben[0]), .halt_ni(hn[0]),
    .as_no(asn[0]), .addr_o(ao[0]), .we_o(wo[0]),
    .ok_o(ok[0]), .ok_halt_o(okh[0]), .trap_o(trp[0]), .retry_o(rty[0]), .halted_o(hlt[0]));

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] strb(input int v);
    return {rty[v], trp[v], okh[v], ok[v]};
  endfunction

  // 1=ok 2=ok_halt 4=trap 8=retry
  function automatic logic [3:0] exp_oc(input bit late, input bit be, input bit h1,
                                        input bit lb, input bit lh);
    if (be) return h1 ? 4'd8 : 4'd4;
    if (!late || !lb) return h1 ? 4'd2 : 4'd1;
    return (h1 || lh) ? 4'd8 : 4'd4;
  endfunction

  // edge index of the decision counted from the cycle start edge
  function automatic int exp_edge(input bit late, input bit be, input int d);
    int k = 5;
    while (k < d + 1) k += 2;
    return (late && !be) ? k + 2 : k;
  endfunction

  task automatic wait_strobe(input int v, output logic [3:0] s, output int n);
    n = 0;
    s = '0;
    while (n < 60) begin
      @(negedge clk);
      n++;
      s = strb(v);
      if (s != 0) break;
    end
  endtask

  task automatic run_cycle(input int v, input bit be, input bit dt, input bit h1,
                           input bit lb, input bit lh, input int d);
    logic [AW-1:0] a0;
    logic          w0;
    logic [3:0]    s, e;
    int            n, extra;
    bit            late, drv;
    string         tag;
    late = (v == 1);
    e    = exp_oc(late, be, h1, lb, lh);
    tag  = be ? (h1 ? "R7" : "R6") : (lb && late) ? "R9" : lb ? "R8" : h1 ? "R5" : "R4";
    a0   = AW'($urandom);
    w0   = 1'($urandom);
    @(negedge clk);
    req[v] = 1'b1; ai[v] = a0; wi[v] = w0;
    n = 0;
    while (asn[v] && n < 20) begin @(negedge clk); n++; end
    chk(!asn[v] && ao[v] == a0 && wo[v] == w0, "R2 start", int'(ao[v]), int'(a0));
    req[v] = 1'b0;
    repeat (d) @(negedge clk);
    n = d;
    dtn[v] = !dt; ben[v] = !be; hn[v] = !h1;
    drv = 1'b0;
    s = '0;
    while (n < 60) begin
      @(negedge clk);
      n++;
      s = strb(v);
      if (s != 0) break;
      if (late && lb && !drv && asn[v]) begin
        ben[v] = 1'b0;
        hn[v]  = !(h1 || lh);
        drv    = 1'b1;
      end
    end
    chk(s == e, tag, int'(s), int'(e));
    chk(n == exp_edge(late, be, d), "R3 sample edge", n, exp_edge(late, be, d));
    if (!late && lb) begin
      ben[v] = 1'b0;
      hn[v]  = !(h1 || lh);
    end
    extra = 0;
    repeat (4) begin
      @(negedge clk);
      if (strb(v) != 0) extra++;
    end
    chk(extra == 0, lb && !late ? "R8 no late effect" : "R10 single strobe", extra, 0);
    dtn[v] = 1'b1; ben[v] = 1'b1;
    if (s == 4'd2 || s == 4'd8) begin
      chk(hlt[v] == 1'b1, s == 4'd8 ? "R7 halted" : "R5 halted", int'(hlt[v]), 1);
      if (s == 4'd8) begin
        req[v] = 1'b1; ai[v] = ~a0; wi[v] = ~w0;
      end
      repeat (3) begin
        @(negedge clk);
        chk(asn[v] && hlt[v], s == 4'd8 ? "R11 held off" : "R5 held off",
            int'({asn[v], hlt[v]}), 3);
      end
      hn[v] = 1'b1; req[v] = 1'b0;
      @(negedge clk);
      if (s == 4'd8) begin
        chk(!asn[v] && ao[v] == a0 && wo[v] == w0, "R11 reissue", int'(ao[v]), int'(a0));
        dtn[v] = 1'b0;
        wait_strobe(v, s, n);
        chk(s == 4'd1, "R11 retried cycle ok", int'(s), 1);
        dtn[v] = 1'b1;
      end else begin
        chk(!hlt[v] && asn[v], "R5 resume", int'(hlt[v]), 0);
      end
    end else begin
      hn[v] = 1'b1;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [3:0] s;
    int n;
    void'($urandom(32'h5eed_0bc7));
    for (int v = 0; v < 2; v++) begin
      req[v] = 1'b0; ai[v] = '0; wi[v] = 1'b0;
      dtn[v] = 1'b1; ben[v] = 1'b1; hn[v] = 1'b1;
    end
    repeat (3) @(negedge clk);
    for (int v = 0; v < 2; v++)
      chk(asn[v] && strb(v) == 0 && !hlt[v], "R1 in reset", int'({asn[v], strb(v), hlt[v]}), 32);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 2; v++)
      chk(asn[v] && strb(v) == 0 && !hlt[v], "R1 after reset", int'({asn[v], strb(v), hlt[v]}), 32);

    // R2: request blocked while acknowledge still low
    dtn[1] = 1'b0;
    @(negedge clk);
    req[1] = 1'b1; ai[1] = 24'h00a5a5; wi[1] = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(asn[1], "R2 blocked", int'(asn[1]), 1);
    end
    dtn[1] = 1'b1;
    @(negedge clk);
    chk(!asn[1] && ao[1] == 24'h00a5a5, "R2 start after release", int'(ao[1]), 24'h00a5a5);
    req[1] = 1'b0;
    dtn[1] = 1'b0;
    wait_strobe(1, s, n);
    chk(s == 4'd1, "R4 after blocked start", int'(s), 1);
    dtn[1] = 1'b1;
    repeat (2) @(negedge clk);

    // directed table rows, both variants
    for (int v = 0; v < 2; v++) begin
      run_cycle(v, 0, 1, 0, 0, 0, 0);
      run_cycle(v, 0, 1, 1, 0, 0, 2);
      run_cycle(v, 1, 0, 0, 0, 0, 5);
      run_cycle(v, 1, 1, 0, 0, 0, 1);
      run_cycle(v, 1, 0, 1, 0, 0, 3);
      run_cycle(v, 1, 1, 1, 0, 0, 6);
      run_cycle(v, 0, 1, 0, 1, 0, 4);
      run_cycle(v, 0, 1, 0, 1, 1, 0);
      run_cycle(v, 0, 1, 1, 1, 0, 2);
    end

    // random mix
    for (int i = 0; i < 120; i++) begin
      bit be, dt, h1, lb, lh;
      be = 1'($urandom);
      dt = be ? 1'($urandom) : 1'b1;
      h1 = 1'($urandom);
      lb = !be && 1'($urandom);
      lh = lb && 1'($urandom);
      run_cycle(i % 2, be, dt, h1, lb, lh, int'($urandom % 7));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule